// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a synchronous, counter-timed monostable. A qualified edge on either of its two trigger inputs makes `q_o` go high for a set number of clock cycles. `qn_o` always carries the complement of `q_o`. The pulse length is set by a parameter. One instance models one channel; two instances give a dual part.

The two trigger inputs respond to opposite edges, and each is gated by the level of the other. `trig_rise_i` fires on a rising edge, but only while `trig_fall_i` is high. `trig_fall_i` fires on a falling edge, but only while `trig_rise_i` is low. Both need the active-low clear to be released. A qualified edge that arrives during a pulse restarts the full interval, so the pulse is stretched.

Pulling `clr_n_i` low ends any pulse and blocks all triggers. When clear is released, a short recovery window follows. Edges that arrive during that window are dropped. All three inputs pass through a synchronizer of `SYNC_STAGES` flops before edge detection. The delay from an input change to `q_o` rising is therefore `SYNC_STAGES + 1` cycles.

Top module: `oneshot_pulse`

## Requirements
- R1: A rising edge on `trig_rise_i` while `trig_fall_i` is 1 and `clr_n_i` is 1 drives `q_o` to 1 exactly `SYNC_STAGES + 1` clock cycles after the input changes.
- R2: A falling edge on `trig_fall_i` while `trig_rise_i` is 0 and `clr_n_i` is 1 starts a pulse with the same latency as R1.
- R3: The following edges start no pulse: a rising edge of `trig_rise_i` while `trig_fall_i` is 0; a falling edge of `trig_fall_i` while `trig_rise_i` is 1; a falling edge of `trig_rise_i`; a rising edge of `trig_fall_i`.
- R4: After a single qualified trigger, `q_o` stays 1 for exactly `PULSE_CYCLES` cycles (minimum 1). The first of those cycles is a one-cycle initialization phase.
- R5: A qualified trigger while `q_o` is 1 restarts the interval. `q_o` then stays 1 until `PULSE_CYCLES` cycles after the last trigger took effect.
- R6: When `clr_n_i` goes low in the middle of a pulse, `q_o` goes to 0 within `SYNC_STAGES + 1` cycles, giving a pulse shorter than `PULSE_CYCLES`.
- R7: While `clr_n_i` is held low, edges on either trigger input leave `q_o` at 0.
- R8: After the synchronized `clr_n_i` returns high, the block spends `RECOVER_CYCLES` cycles in recovery. Triggers seen during recovery are dropped; later triggers are accepted.
- R9: `qn_o` always equals the inverse of `q_o`. After reset, `q_o` is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_rise_i | input | 1 | Rising-edge trigger, qualified by `trig_fall_i` high |
| trig_fall_i | input | 1 | Falling-edge trigger, qualified by `trig_rise_i` low |
| clr_n_i | input | 1 | Active-low clear; ends the pulse and blocks triggers |
| q_o | output | 1 | Pulse output |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
The embedded assertions check, on every cycle, the following rules:
- a synchronized low clear drops `q_o` on the next cycle;
- an accepted trigger raises `q_o` on the next cycle;
- recovery never leads straight into a new pulse;
- an expiring count ends the pulse;
- a trigger only fires on an actual input change.

Only the directed scenarios can show the end-to-end figures. These are the exact pulse width, the stretch produced by a retrigger, the latency from the pins through the synchronizers, and that each non-qualifying edge leaves the output quiet.

// File: rtl/oneshot_pkg.sv
// Shared types for the one-shot pulse generator.
package oneshot_pkg;

    // Timing-engine phases.
    typedef enum logic [1:0] {
        OS_IDLE    = 2'd0,
        OS_INIT    = 2'd1,
        OS_RUN     = 2'd2,
        OS_RECOVER = 2'd3
    } os_state_e;

endpackage

// File: rtl/os_sync.sv
// Multi-flop synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is independent; RST_VAL gives the idle level per bit.
module os_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/os_trig_detect.sv
// Edge detector with cross-qualification of the two trigger inputs.
// Assumes: inputs are already synchronized to clk.
module os_trig_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_s_i,
    input  logic fall_s_i,
    input  logic clr_s_i,
    output logic trig_o
);

    logic rise_p_q;
    logic fall_p_q;
    logic rise_edge;
    logic fall_edge;

    // Keep the previous sampled level of each trigger input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_p_q <= 1'b0;
            fall_p_q <= 1'b1;
        end else begin
            rise_p_q <= rise_s_i;
            fall_p_q <= fall_s_i;
        end
    end

    // Decode the edges and apply the qualifying levels.
    always_comb begin
        rise_edge = rise_s_i & ~rise_p_q;
        fall_edge = fall_p_q & ~fall_s_i;
        trig_o    = clr_s_i & ((rise_edge & fall_s_i) | (fall_edge & ~rise_s_i));
    end

    AST_EDGE_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (rise_s_i != $past(rise_s_i)) || (fall_s_i != $past(fall_s_i))); // R3

endmodule

// File: rtl/os_timer.sv
// Pulse timing engine: init phase, timed run, and post-clear recovery.
// Assumes: trig_i is a single-cycle qualified strobe; clr_s_i is synchronized.
module os_timer
    import oneshot_pkg::*;
#(
    parameter int PULSE_CYCLES   = 8,
    parameter int RECOVER_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic clr_s_i,
    output logic q_o
);

    localparam int CNT_MAX = (PULSE_CYCLES > RECOVER_CYCLES) ? PULSE_CYCLES : RECOVER_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYCLES - 1);
    localparam logic [CNT_W-1:0] REC_LOAD   = CNT_W'(RECOVER_CYCLES);

    os_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance the phase machine and its shared down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
            cnt_q   <= '0;
        end else if (!clr_s_i) begin
            state_q <= OS_RECOVER;
            cnt_q   <= REC_LOAD;
        end else begin
            unique case (state_q)
                OS_RECOVER: begin
                    if (cnt_q <= CNT_W'(1)) begin
                        state_q <= OS_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    if (trig_i) begin
                        state_q <= OS_INIT;
                        cnt_q   <= PULSE_LOAD;
                    end else if (state_q != OS_IDLE) begin
                        if (cnt_q == '0) begin
                            state_q <= OS_IDLE;
                        end else begin
                            state_q <= OS_RUN;
                            cnt_q   <= cnt_q - 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Output is high through the init and run phases.
    assign q_o = (state_q == OS_INIT) || (state_q == OS_RUN);

    AST_CLEAR_DROPS_Q: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s_i |=> !q_o); // R6
    AST_TRIG_SETS_Q: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && clr_s_i && state_q != OS_RECOVER) |=> q_o); // R1
    AST_RECOVER_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OS_RECOVER) |=> (state_q != OS_INIT)); // R8
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OS_RUN && cnt_q == '0 && !trig_i && clr_s_i) |=> !q_o); // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CNT_MAX)); // R4

endmodule

// File: rtl/oneshot_pulse.sv
// Retriggerable one-shot: synchronizes inputs, qualifies edges, times pulse.
// Assumes: PULSE_CYCLES >= 1, RECOVER_CYCLES >= 1, SYNC_STAGES >= 1.
module oneshot_pulse #(
    parameter int PULSE_CYCLES   = 8,
    parameter int RECOVER_CYCLES = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_rise_i,
    input  logic trig_fall_i,
    input  logic clr_n_i,
    output logic q_o,
    output logic qn_o
);

    localparam int IN_W = 3;

    logic [IN_W-1:0] raw_in;
    logic [IN_W-1:0] sync_in;
    logic            trig;
    logic            q_int;

    assign raw_in = {clr_n_i, trig_fall_i, trig_rise_i};

    os_sync #(
        .WIDTH   (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    os_trig_detect detect_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_s_i (sync_in[0]),
        .fall_s_i (sync_in[1]),
        .clr_s_i  (sync_in[2]),
        .trig_o   (trig)
    );

    os_timer #(
        .PULSE_CYCLES   (PULSE_CYCLES),
        .RECOVER_CYCLES (RECOVER_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig),
        .clr_s_i (sync_in[2]),
        .q_o     (q_int)
    );

    // Drive both polarities from the single timed level.
    assign q_o  = q_int;
    assign qn_o = ~q_int;

endmodule

// File: tb/oneshot_pulse_tb_top.sv
`timescale 1ns/1ps
module oneshot_pulse_tb_top;

    localparam int T   = 8;
    localparam int REC = 4;
    localparam int SYN = 2;
    localparam int LAT = SYN + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 1'b0;
    logic b = 1'b1;
    logic clr_n = 1'b1;
    logic q, qn;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    oneshot_pulse #(
        .PULSE_CYCLES   (T),
        .RECOVER_CYCLES (REC),
        .SYNC_STAGES    (SYN)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_rise_i (a),
        .trig_fall_i (b),
        .clr_n_i     (clr_n),
        .q_o         (q),
        .qn_o        (qn)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts consecutive high samples of q starting at the current negedge.
    task automatic measure_high(output int n);
        n = 0;
        while (q && n < 100) begin
            if (qn !== ~q) check_eq("R9 complement", int'(qn), int'(~q));
            n++;
            tick(1);
        end
    endtask

    // Verifies q stays low for n cycles.
    task automatic expect_quiet(input string req, input int n);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (q) hits++;
        end
        check_eq(req, hits, 0);
    endtask

    task automatic test_reset();
        check_eq("R9 reset q", int'(q), 0);
        check_eq("R9 reset qn", int'(qn), 1);
    endtask

    task automatic test_single_rise();
        int w;
        a = 1'b1;
        tick(LAT - 1);
        check_eq("R1 not early", int'(q), 0);
        tick(1);
        check_eq("R1 latency", int'(q), 1);
        measure_high(w);
        check_eq("R4 width", w, T);
        check_eq("R9 idle qn", int'(qn), 1);
        a = 1'b0;
        tick(5);
    endtask

    task automatic test_fall_trigger();
        int w;
        b = 1'b0;
        tick(LAT - 1);
        check_eq("R2 not early", int'(q), 0);
        tick(1);
        check_eq("R2 latency", int'(q), 1);
        measure_high(w);
        check_eq("R2 width", w, T);
        b = 1'b1;
        tick(5);
    endtask

    task automatic test_retrigger();
        int w;
        a = 1'b1;
        tick(LAT);
        check_eq("R5 first pulse", int'(q), 1);
        a = 1'b0;
        tick(3);
        a = 1'b1;
        w = 0;
        tick(1);
        while (q && w < 100) begin
            w++;
            tick(1);
        end
        check_eq("R5 stretched width", w, T + LAT - 1);
        a = 1'b0;
        tick(5);
    endtask

    task automatic test_clear();
        a = 1'b1;
        tick(LAT + 2);
        check_eq("R6 pulse running", int'(q), 1);
        clr_n = 1'b0;
        tick(LAT);
        check_eq("R6 early end", int'(q), 0);
        check_eq("R6 qn high", int'(qn), 1);
        a = 1'b0;
        tick(2);
        a = 1'b1;
        expect_quiet("R7 rise blocked", 8);
        a = 1'b0;
        b = 1'b0;
        expect_quiet("R7 fall blocked", 8);
        b = 1'b1;
        tick(4);
        clr_n = 1'b1;
        a = 1'b1;
        expect_quiet("R8 recovery drop", 12);
        a = 1'b0;
        tick(3);
        a = 1'b1;
        tick(LAT);
        check_eq("R8 accepted after", int'(q), 1);
        a = 1'b0;
        tick(T + 4);
    endtask

    task automatic test_qualify();
        int w;
        a = 1'b1;
        tick(LAT);
        measure_high(w);
        check_eq("R3 setup pulse", w, T);
        b = 1'b0;
        expect_quiet("R3 fall with A high", 10);
        a = 1'b0;
        expect_quiet("R3 A falling", 10);
        a = 1'b1;
        expect_quiet("R3 rise with B low", 10);
        b = 1'b1;
        expect_quiet("R3 B rising", 10);
        a = 1'b0;
        tick(5);
    endtask

    initial begin
        tick(1);
        test_reset();
        tick(4);
        rst_n = 1'b1;
        tick(3);
        test_reset();
        test_single_rise();
        test_fall_trigger();
        test_retrigger();
        test_clear();
        test_qualify();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule